// File: doc/BRIEF.md
# Four-entry fully associative address translation buffer

The block keeps a handful of recently used page mappings so that a 32-bit virtual address can be turned into a 20-bit physical address without a trip to the page tables. Pages are 32 KiB. The low 15 address bits are the page offset and pass through unchanged. The upper 17 bits form the virtual page number, which is compared against every stored entry at once. A hit returns the 5-bit physical page number joined to the offset, after checking the entry's read, write and execute permissions against the kind of access.

On a miss the block raises a request to an external page-table walker and waits. When the walker answers, the block completes the access. If the page is present, it also stores the new mapping in an empty slot, or otherwise in the least recently used slot. A single-cycle flush input drops every stored mapping when the running process changes.

A requester presents one access while `req_ready` is high. It then waits for the one-cycle `rsp_valid` pulse, which carries the hit flag, the physical address and the two fault flags.

Top module: `xlt_buf`

## Requirements
- R1: A translation without fault returns `rsp_paddr = {ppn, req_vaddr[14:0]}`, where ppn is the 5-bit physical page of the mapping.
- R2: An access accepted while idle (`req_valid` and `req_ready` high, `flush` low) whose page number `req_vaddr[31:15]` matches a valid entry responds in the following cycle with `rsp_valid` and `rsp_hit` high, without using the walker.
- R3: On a miss, `walk_req` rises in the following cycle carrying `walk_vpn = req_vaddr[31:15]`. It stays high with that value, and `req_ready` stays low, until the cycle in which `walk_ack` is sampled. The response, with `rsp_hit` low, follows one cycle after that.
- R4: When the walker answers with `walk_present` high, the mapping is stored, and a later access to the same page hits. A page is never stored twice.
- R5: When the walker answers with `walk_present` low, the response carries `rsp_page_fault` high, `rsp_hit` low and `rsp_prot_fault` low, and nothing is stored. A repeat access misses again.
- R6: `req_kind` is 00 for read, 01 for write, 10 for execute and 11 for an access no permission allows. Permission vectors have read at bit 0, write at bit 1 and execute at bit 2. An access that is not permitted gives `rsp_prot_fault` high and `rsp_paddr` zero.
- R7: A new mapping goes into the lowest-indexed empty entry. If every entry is full, it replaces the least recently used entry. Every hit, including a hit that faults, makes its entry the most recent, and so does every fill.
- R8: A cycle with `flush` high empties every entry by the next cycle. An access presented in that same cycle is discarded and gets no response.
- R9: A flush that arrives while a walk is outstanding does not stop the response to that access. The walker's answer, however, is not stored.
- R10: After reset, all entries are empty, the block is idle with `req_ready` high, and `rsp_valid` and `walk_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 none |
| req_ready | output | 1 | Block idle, request may be accepted |
| flush | input | 1 | Drop all stored mappings |
| walk_req | output | 1 | Walk request, held until acknowledged |
| walk_vpn | output | 17 | Page number to walk |
| walk_ack | input | 1 | Walker answer valid |
| walk_present | input | 1 | Page is present |
| walk_ppn | input | 5 | Physical page from walker |
| walk_perm | input | 3 | Permissions from walker (bit0 read, bit1 write, bit2 execute) |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Served from a stored mapping |
| rsp_paddr | output | 20 | Physical address, zero on any fault |
| rsp_prot_fault | output | 1 | Access kind not permitted |
| rsp_page_fault | output | 1 | Page not present |

## Verification
The bench builds the block with its default parameters: 32-bit virtual and 20-bit physical addresses, a 15-bit offset and four entries. With only four slots, a fifth distinct page already forces an eviction. A pool of eight pages, one of them absent, therefore keeps the recency order, the empty-slot preference and the absent-page path busy all the time. The walker latency is varied from zero to six cycles, which puts a flush both inside a walk and in the same cycle as a request.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

  typedef enum logic [1:0] {
    ACC_RD   = 2'b00,
    ACC_WR   = 2'b01,
    ACC_EX   = 2'b10,
    ACC_NONE = 2'b11
  } acc_kind_e;

  localparam int PERM_BITS = 3;
  localparam int P_RD = 0;
  localparam int P_WR = 1;
  localparam int P_EX = 2;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } xlt_state_e;

  function automatic logic perm_allows(input logic [1:0] kind,
                                       input logic [PERM_BITS-1:0] perm);
    logic ok;
    case (acc_kind_e'(kind))
      ACC_RD:  ok = perm[P_RD];
      ACC_WR:  ok = perm[P_WR];
      ACC_EX:  ok = perm[P_EX];
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/xlt_cam.sv
module xlt_cam #(
  parameter int VPN_W  = 17,
  parameter int PPN_W  = 5,
  parameter int NENT   = 4,
  parameter int PERM_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic [NENT-1:0]   match_vec,
  output logic [PPN_W-1:0]  match_ppn,
  output logic [PERM_W-1:0] match_perm,
  input  logic              clr_all,
  input  logic              wr_en,
  input  logic [NENT-1:0]   wr_sel,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [PERM_W-1:0] wr_perm,
  output logic [NENT-1:0]   valid_vec
);

  logic [VPN_W-1:0]  tag_q  [NENT];
  logic [PPN_W-1:0]  ppn_q  [NENT];
  logic [PERM_W-1:0] perm_q [NENT];
  logic [NENT-1:0]   valid_q;

  // valid bits: reset and flush, separate from the data array
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (clr_all) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q <= valid_q | wr_sel;
    end
  end

  // payload storage, no reset needed
  always_ff @(posedge clk) begin
    for (int i = 0; i < NENT; i++) begin
      if (wr_en && wr_sel[i]) begin
        tag_q[i]  <= wr_vpn;
        ppn_q[i]  <= wr_ppn;
        perm_q[i] <= wr_perm;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NENT; g++) begin : g_cmp
      assign match_vec[g] = valid_q[g] && (tag_q[g] == lk_vpn);
    end
  endgenerate

  // one-hot OR mux of the matching entry
  always_comb begin
    match_ppn  = '0;
    match_perm = '0;
    for (int i = 0; i < NENT; i++) begin
      if (match_vec[i]) begin
        match_ppn  = match_ppn | ppn_q[i];
        match_perm = match_perm | perm_q[i];
      end
    end
  end

  assign valid_vec = valid_q;

endmodule

// File: rtl/xlt_lru.sv
module xlt_lru #(
  parameter int NENT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            touch,
  input  logic [NENT-1:0] touch_vec,
  input  logic [NENT-1:0] valid_vec,
  output logic [NENT-1:0] victim_vec
);

  localparam int AGE_W = (NENT > 1) ? $clog2(NENT) : 1;
  localparam logic [AGE_W-1:0] AGE_OLD = AGE_W'(NENT - 1);

  logic [AGE_W-1:0] age_q [NENT];
  logic [AGE_W-1:0] sel_age;
  logic [NENT-1:0]  free_vec;
  logic [NENT-1:0]  old_vec;
  logic             any_free;

  always_comb begin
    sel_age = '0;
    for (int i = 0; i < NENT; i++) begin
      if (touch_vec[i]) sel_age = sel_age | age_q[i];
    end
  end

  // ages form a permutation of 0..NENT-1; 0 is most recent
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NENT; i++) age_q[i] <= AGE_W'(i);
    end else if (touch) begin
      for (int i = 0; i < NENT; i++) begin
        if (touch_vec[i]) begin
          age_q[i] <= '0;
        end else if (age_q[i] < sel_age) begin
          age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NENT; g++) begin : g_old
      assign old_vec[g] = (age_q[g] == AGE_OLD);
    end
  endgenerate

  always_comb begin
    free_vec = '0;
    any_free = 1'b0;
    for (int i = 0; i < NENT; i++) begin
      if (!valid_vec[i] && !any_free) begin
        free_vec[i] = 1'b1;
        any_free    = 1'b1;
      end
    end
  end

  assign victim_vec = any_free ? free_vec : old_vec;

endmodule

// File: rtl/xlt_ctrl.sv
module xlt_ctrl
  import xlt_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 20,
  parameter int PG_W   = 15,
  parameter int NENT   = 4,
  parameter int PERM_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [VA_W-1:0]      req_vaddr,
  input  logic [1:0]           req_kind,
  input  logic                 flush,
  output logic                 req_ready,
  input  logic [NENT-1:0]      match_vec,
  input  logic [PA_W-PG_W-1:0] match_ppn,
  input  logic [PERM_W-1:0]    match_perm,
  input  logic [NENT-1:0]      victim_vec,
  output logic                 walk_req,
  output logic [VA_W-PG_W-1:0] walk_vpn,
  input  logic                 walk_ack,
  input  logic                 walk_present,
  input  logic [PA_W-PG_W-1:0] walk_ppn,
  input  logic [PERM_W-1:0]    walk_perm,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [PA_W-1:0]      rsp_paddr,
  output logic                 rsp_prot_fault,
  output logic                 rsp_page_fault,
  output logic                 cam_clr,
  output logic                 cam_wr,
  output logic [NENT-1:0]      cam_sel,
  output logic [VA_W-PG_W-1:0] cam_vpn,
  output logic [PA_W-PG_W-1:0] cam_ppn,
  output logic [PERM_W-1:0]    cam_perm,
  output logic                 lru_touch,
  output logic [NENT-1:0]      lru_vec
);

  localparam int VPN_W = VA_W - PG_W;

  xlt_state_e       st_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PG_W-1:0]  off_q;
  logic [1:0]       kind_q;
  logic             drop_q;

  logic accept, hit_any, done, install, hit_ok, fill_ok;

  assign accept  = (st_q == ST_IDLE) && req_valid && !flush;
  assign hit_any = |match_vec;
  assign done    = (st_q == ST_WALK) && walk_ack;
  assign install = done && walk_present && !drop_q && !flush;
  assign hit_ok  = perm_allows(req_kind, match_perm);
  assign fill_ok = perm_allows(kind_q, walk_perm);

  assign cam_clr   = flush;
  assign cam_wr    = install;
  assign cam_sel   = victim_vec;
  assign cam_vpn   = vpn_q;
  assign cam_ppn   = walk_ppn;
  assign cam_perm  = walk_perm;
  assign lru_touch = (accept && hit_any) || install;
  assign lru_vec   = install ? victim_vec : match_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= ST_IDLE;
      vpn_q          <= '0;
      off_q          <= '0;
      kind_q         <= '0;
      drop_q         <= 1'b0;
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_paddr      <= '0;
      rsp_prot_fault <= 1'b0;
      rsp_page_fault <= 1'b0;
    end else begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_paddr      <= '0;
      rsp_prot_fault <= 1'b0;
      rsp_page_fault <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (hit_any) begin
              rsp_valid      <= 1'b1;
              rsp_hit        <= 1'b1;
              rsp_prot_fault <= !hit_ok;
              rsp_paddr      <= hit_ok ? {match_ppn, req_vaddr[PG_W-1:0]} : '0;
            end else begin
              st_q   <= ST_WALK;
              vpn_q  <= req_vaddr[VA_W-1:PG_W];
              off_q  <= req_vaddr[PG_W-1:0];
              kind_q <= req_kind;
              drop_q <= 1'b0;
            end
          end
        end
        ST_WALK: begin
          if (walk_ack) begin
            st_q      <= ST_IDLE;
            rsp_valid <= 1'b1;
            if (!walk_present) begin
              rsp_page_fault <= 1'b1;
            end else begin
              rsp_prot_fault <= !fill_ok;
              rsp_paddr      <= fill_ok ? {walk_ppn, off_q} : '0;
            end
          end else if (flush) begin
            drop_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign walk_req  = (st_q == ST_WALK);
  assign walk_vpn  = vpn_q;

endmodule

// File: rtl/xlt_buf.sv
module xlt_buf #(
  parameter int VA_W = 32,
  parameter int PA_W = 20,
  parameter int PG_W = 15,
  parameter int NENT = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [VA_W-1:0]      req_vaddr,
  input  logic [1:0]           req_kind,
  output logic                 req_ready,
  input  logic                 flush,
  output logic                 walk_req,
  output logic [VA_W-PG_W-1:0] walk_vpn,
  input  logic                 walk_ack,
  input  logic                 walk_present,
  input  logic [PA_W-PG_W-1:0] walk_ppn,
  input  logic [2:0]           walk_perm,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic [PA_W-1:0]      rsp_paddr,
  output logic                 rsp_prot_fault,
  output logic                 rsp_page_fault
);

  localparam int VPN_W  = VA_W - PG_W;
  localparam int PPN_W  = PA_W - PG_W;
  localparam int PERM_W = xlt_pkg::PERM_BITS;

  logic [NENT-1:0]   match_vec;
  logic [NENT-1:0]   valid_vec;
  logic [NENT-1:0]   victim_vec;
  logic [PPN_W-1:0]  match_ppn;
  logic [PERM_W-1:0] match_perm;
  logic              cam_clr, cam_wr, lru_touch;
  logic [NENT-1:0]   cam_sel, lru_vec;
  logic [VPN_W-1:0]  cam_vpn;
  logic [PPN_W-1:0]  cam_ppn;
  logic [PERM_W-1:0] cam_perm;

  xlt_cam #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .NENT(NENT), .PERM_W(PERM_W)
  ) u_cam (
    .clk        (clk),
    .rst        (rst),
    .lk_vpn     (req_vaddr[VA_W-1:PG_W]),
    .match_vec  (match_vec),
    .match_ppn  (match_ppn),
    .match_perm (match_perm),
    .clr_all    (cam_clr),
    .wr_en      (cam_wr),
    .wr_sel     (cam_sel),
    .wr_vpn     (cam_vpn),
    .wr_ppn     (cam_ppn),
    .wr_perm    (cam_perm),
    .valid_vec  (valid_vec)
  );

  xlt_lru #(.NENT(NENT)) u_lru (
    .clk        (clk),
    .rst        (rst),
    .touch      (lru_touch),
    .touch_vec  (lru_vec),
    .valid_vec  (valid_vec),
    .victim_vec (victim_vec)
  );

  xlt_ctrl #(
    .VA_W(VA_W), .PA_W(PA_W), .PG_W(PG_W), .NENT(NENT), .PERM_W(PERM_W)
  ) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_vaddr      (req_vaddr),
    .req_kind       (req_kind),
    .flush          (flush),
    .req_ready      (req_ready),
    .match_vec      (match_vec),
    .match_ppn      (match_ppn),
    .match_perm     (match_perm),
    .victim_vec     (victim_vec),
    .walk_req       (walk_req),
    .walk_vpn       (walk_vpn),
    .walk_ack       (walk_ack),
    .walk_present   (walk_present),
    .walk_ppn       (walk_ppn),
    .walk_perm      (walk_perm),
    .rsp_valid      (rsp_valid),
    .rsp_hit        (rsp_hit),
    .rsp_paddr      (rsp_paddr),
    .rsp_prot_fault (rsp_prot_fault),
    .rsp_page_fault (rsp_page_fault),
    .cam_clr        (cam_clr),
    .cam_wr         (cam_wr),
    .cam_sel        (cam_sel),
    .cam_vpn        (cam_vpn),
    .cam_ppn        (cam_ppn),
    .cam_perm       (cam_perm),
    .lru_touch      (lru_touch),
    .lru_vec        (lru_vec)
  );

endmodule

// File: rtl/xlt_buf_chk.sv
module xlt_buf_chk #(
  parameter int NENT  = 4,
  parameter int VPN_W = 17,
  parameter int PA_W  = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             flush,
  input logic             walk_req,
  input logic             walk_ack,
  input logic [VPN_W-1:0] walk_vpn,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [PA_W-1:0]  rsp_paddr,
  input logic             rsp_prot_fault,
  input logic             rsp_page_fault,
  input logic [NENT-1:0]  valid_vec,
  input logic [NENT-1:0]  match_vec,
  input logic [NENT-1:0]  victim_vec
);

  // R3
  walk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    walk_req && !walk_ack |=> walk_req && $stable(walk_vpn));

  // R3
  walk_busy_chk: assert property (@(posedge clk) disable iff (rst)
    walk_req |-> !req_ready);

  // R2
  rsp_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(req_valid && req_ready && !flush) || $past(walk_req && walk_ack)));

  // R5
  page_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_page_fault |-> rsp_valid && !rsp_hit && !rsp_prot_fault);

  // R6
  prot_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_prot_fault |-> rsp_valid && (rsp_paddr == '0));

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_vec == '0));

  // R4
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));

  // R7
  victim_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot(victim_vec));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !rsp_valid && !walk_req && req_ready && (valid_vec == '0));

endmodule

bind xlt_buf xlt_buf_chk #(.NENT(NENT), .VPN_W(VPN_W), .PA_W(PA_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_ready      (req_ready),
  .flush          (flush),
  .walk_req       (walk_req),
  .walk_ack       (walk_ack),
  .walk_vpn       (walk_vpn),
  .rsp_valid      (rsp_valid),
  .rsp_hit        (rsp_hit),
  .rsp_paddr      (rsp_paddr),
  .rsp_prot_fault (rsp_prot_fault),
  .rsp_page_fault (rsp_page_fault),
  .valid_vec      (valid_vec),
  .match_vec      (match_vec),
  .victim_vec     (victim_vec)
);

// File: tb/sim_xlt_buf.sv
module sim_xlt_buf;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_ready;
  logic        flush = 1'b0;
  logic        walk_req;
  logic [16:0] walk_vpn;
  logic        walk_ack = 1'b0;
  logic        walk_present = 1'b0;
  logic [4:0]  walk_ppn = '0;
  logic [2:0]  walk_perm = '0;
  logic        rsp_valid, rsp_hit, rsp_prot_fault, rsp_page_fault;
  logic [19:0] rsp_paddr;

  xlt_buf u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_ready(req_ready), .flush(flush),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_ack(walk_ack),
    .walk_present(walk_present), .walk_ppn(walk_ppn), .walk_perm(walk_perm),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .rsp_prot_fault(rsp_prot_fault), .rsp_page_fault(rsp_page_fault)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // page table seen by the walker
  function automatic bit pt_present(input int vpn);
    return (vpn & 'hF) != 'hF;
  endfunction
  function automatic int pt_ppn(input int vpn);
    return (vpn ^ (vpn >> 5) ^ 3) & 'h1F;
  endfunction
  function automatic int pt_perm(input int vpn);
    return (vpn >> 4) & 7;
  endfunction
  function automatic bit allowed(input int kind, input int perm);
    if (kind == 0) return perm[0];
    if (kind == 1) return perm[1];
    if (kind == 2) return perm[2];
    return 0;
  endfunction

  // walker
  int lat = 1;
  int cnt = 1;
  always @(negedge clk) begin
    if (walk_ack) begin
      walk_ack = 1'b0;
      cnt = lat;
    end else if (walk_req) begin
      if (cnt <= 0) begin
        walk_ack     = 1'b1;
        walk_present = pt_present(int'(walk_vpn));
        walk_ppn     = 5'(pt_ppn(int'(walk_vpn)));
        walk_perm    = 3'(pt_perm(int'(walk_vpn)));
      end else begin
        cnt--;
      end
    end else begin
      cnt = lat;
    end
  end

  // reference model
  bit m_v [4];
  int m_tag [4];
  int m_ppn [4];
  int m_perm [4];
  int order [$];
  int m_st = 0;
  int m_vpn = 0;
  int m_off = 0;
  int m_kind = 0;
  bit m_drop = 0;
  bit e_rv, e_hit, e_pf, e_prf;
  int e_pa;
  bit started = 0;

  function automatic void touch(input int i);
    for (int k = 0; k < order.size(); k++) begin
      if (order[k] == i) begin
        order.delete(k);
        break;
      end
    end
    order.push_front(i);
  endfunction

  function automatic void install(input int vpn, input int ppn, input int perm);
    int v;
    v = -1;
    for (int i = 0; i < 4; i++) if (!m_v[i] && v < 0) v = i;
    if (v < 0) v = order[$];
    m_v[v] = 1; m_tag[v] = vpn; m_ppn[v] = ppn; m_perm[v] = perm;
    touch(v);
  endfunction

  always @(posedge clk) begin
    int idx, vpn, off, kind;
    bit ok;
    started = 1;
    if (rst) begin
      for (int i = 0; i < 4; i++) m_v[i] = 0;
      order = '{0, 1, 2, 3};
      m_st = 0; m_drop = 0;
      e_rv = 0; e_hit = 0; e_pf = 0; e_prf = 0; e_pa = 0;
    end else begin
      e_rv = 0; e_hit = 0; e_pf = 0; e_prf = 0; e_pa = 0;
      if (m_st == 1) begin
        if (walk_ack) begin
          e_rv = 1;
          if (!walk_present) e_pf = 1;
          else begin
            ok = allowed(m_kind, int'(walk_perm));
            e_prf = !ok;
            e_pa = ok ? ((int'(walk_ppn) << 15) | m_off) : 0;
            if (!m_drop && !flush) install(m_vpn, int'(walk_ppn), int'(walk_perm));
          end
          m_st = 0;
        end
      end else if (req_valid && !flush) begin
        vpn = int'(req_vaddr[31:15]);
        off = int'(req_vaddr[14:0]);
        kind = int'(req_kind);
        idx = -1;
        for (int i = 0; i < 4; i++) if (m_v[i] && m_tag[i] == vpn) idx = i;
        if (idx >= 0) begin
          touch(idx);
          ok = allowed(kind, m_perm[idx]);
          e_rv = 1; e_hit = 1; e_prf = !ok;
          e_pa = ok ? ((m_ppn[idx] << 15) | off) : 0;
        end else begin
          m_st = 1; m_vpn = vpn; m_off = off; m_kind = kind; m_drop = 0;
        end
      end
      if (flush) begin
        for (int i = 0; i < 4; i++) m_v[i] = 0;
        if (m_st == 1) m_drop = 1;
      end
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R2", "rsp_valid", rsp_valid, e_rv);
      chk("R2", "rsp_hit", rsp_hit, e_hit);
      chk("R1", "rsp_paddr", rsp_paddr, e_pa);
      chk("R5", "rsp_page_fault", rsp_page_fault, e_pf);
      chk("R6", "rsp_prot_fault", rsp_prot_fault, e_prf);
      chk("R3", "walk_req", walk_req, (m_st == 1));
      chk("R3", "req_ready", req_ready, (m_st == 0));
      if (m_st == 1) chk("R3", "walk_vpn", walk_vpn, m_vpn);
    end
  end

  task automatic access(input int vpn, input int off, input int kind,
                        output bit hit, output bit pf, output bit prf, output int pa);
    int guard;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = {17'(vpn), 15'(off)};
    req_kind  = 2'(kind);
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_valid && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    hit = rsp_hit; pf = rsp_page_fault; prf = rsp_prot_fault; pa = int'(rsp_paddr);
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  function automatic int xpa(input int vpn, input int off);
    return (pt_ppn(vpn) << 15) | off;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    report();
  end

  localparam int VA = 'h070;  // rwx
  localparam int VB = 'h010;  // read only
  localparam int VC = 'h020;
  localparam int VD = 'h040;
  localparam int VE = 'h030;
  localparam int VF = 'h00F;  // absent
  localparam int VG = 'h050;
  localparam int VH = 'h060;

  initial begin
    bit h, pf, prf;
    int pa;
    int pool [8];
    pool = '{VA, VB, VC, VD, VE, 'h05F, VH, 'h0A0};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "rsp_valid after reset", rsp_valid, 0);
    chk("R10", "walk_req after reset", walk_req, 0);
    chk("R10", "req_ready after reset", req_ready, 1);

    access(VA, 'h1234, 0, h, pf, prf, pa);
    chk("R3", "first access misses", h, 0);
    chk("R1", "paddr from walk", pa, xpa(VA, 'h1234));
    access(VA, 'h7FFF, 2, h, pf, prf, pa);
    chk("R4", "second access hits", h, 1);
    chk("R1", "paddr from hit", pa, xpa(VA, 'h7FFF));

    access(VB, 'h0010, 0, h, pf, prf, pa);
    access(VB, 'h0020, 1, h, pf, prf, pa);
    chk("R6", "write to read-only faults", prf, 1);
    chk("R6", "faulting paddr zero", pa, 0);
    access(VB, 'h0030, 3, h, pf, prf, pa);
    chk("R6", "kind 11 faults", prf, 1);
    access(VB, 'h0040, 0, h, pf, prf, pa);
    chk("R6", "read allowed", prf, 0);

    access(VC, 0, 0, h, pf, prf, pa);
    access(VD, 0, 0, h, pf, prf, pa);
    access(VA, 0, 0, h, pf, prf, pa);
    chk("R7", "A still held", h, 1);
    access(VE, 0, 0, h, pf, prf, pa);
    chk("R7", "E misses", h, 0);
    access(VA, 0, 0, h, pf, prf, pa);
    chk("R7", "recent A survives eviction", h, 1);
    access(VB, 0, 0, h, pf, prf, pa);
    chk("R7", "LRU B was evicted", h, 0);
    access(VD, 0, 0, h, pf, prf, pa);
    chk("R7", "D kept", h, 1);
    access(VC, 0, 0, h, pf, prf, pa);
    chk("R7", "C was evicted", h, 0);

    access(VF, 5, 0, h, pf, prf, pa);
    chk("R5", "absent page faults", pf, 1);
    access(VF, 5, 0, h, pf, prf, pa);
    chk("R5", "absent page not stored", h, 0);
    chk("R5", "absent page faults again", pf, 1);

    pulse_flush();
    access(VA, 1, 0, h, pf, prf, pa);
    chk("R8", "miss after flush", h, 0);

    @(negedge clk);
    flush = 1'b1; req_valid = 1'b1; req_vaddr = {17'(VA), 15'd2}; req_kind = 2'd0;
    @(negedge clk);
    flush = 1'b0; req_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R8", "request with flush discarded", rsp_valid, 0);
      chk("R8", "no walk for discarded request", walk_req, 0);
      @(negedge clk);
    end
    access(VA, 3, 0, h, pf, prf, pa);
    chk("R8", "flush with request emptied A", h, 0);

    lat = 6;
    fork
      access(VG, 'h55, 0, h, pf, prf, pa);
      begin
        repeat (3) @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
      end
    join
    chk("R9", "response survives flush", pa, xpa(VG, 'h55));
    lat = 1;
    access(VG, 'h56, 0, h, pf, prf, pa);
    chk("R9", "walk result not stored", h, 0);

    lat = 0;
    access(VH, 9, 2, h, pf, prf, pa);
    chk("R3", "zero-latency walk miss", h, 0);
    access(VH, 9, 2, h, pf, prf, pa);
    chk("R4", "zero-latency fill hits", h, 1);

    for (int n = 0; n < 600; n++) begin
      lat = int'($urandom % 4);
      if ($urandom % 25 == 0) pulse_flush();
      access(pool[$urandom % 8], int'($urandom % 32768), int'($urandom % 4), h, pf, prf, pa);
    end

    repeat (3) @(negedge clk);
    report();
  end

endmodule